// File: doc/BRIEF.md
# Variable-Size Page Translation and Fault Check

This block sits after the associative search in a memory management unit. For each request it receives the hit or miss result, the page-size mask of the matching entry, and the two halves of that entry. One half maps the even page of the pair and the other maps the odd page. The block decodes the page size from the mask. The decoded size fixes which virtual address bit picks the even or odd half, and it also fixes where the frame number is joined to the page offset.

It then checks the chosen half's valid and dirty bits against the access type and forms a zero-extended 64-bit physical address. It also returns the capability flag that belongs to the access type. A miss, an invalid half or a store to a clean page gives a 3-bit fault code with a strobe. A mask that is not a legal size gives a separate illegal-mask flag. The response is registered and appears one clock after the request.

Top module: `page_xlate`

## Requirements
- R1: A mask equal to 2^(2k)-1 for k in 0..8 (0x0000, 0x0003, ... 0xFFFF) is legal and selects the page-select bit position 12+2k.
- R2: On a hit with any other mask value, `badMask` is 1, `faultValid` is 0, `faultCode` is 0, `physAddr` is 0 and `capFlag` is 0.
- R3: The virtual address bit at the select position chooses the odd half when it is 1 and the even half when it is 0.
- R4: On a miss, `faultValid` is 1 and `faultCode` is 1 for a load or 2 for a store, whatever the mask is, and `badMask` is 0.
- R5: On a legal hit whose selected half has valid clear, `faultCode` is 3 for a load or 4 for a store, with `faultValid` set.
- R6: A store to a valid half with dirty clear gives `faultCode` 5. A load to such a half translates without a fault.
- R7: With no fault, `physAddr` is {frame[23:sel-12], vAddr[sel-1:0]} (36 bits), zero-extended to 64 bits.
- R8: With no fault, `capFlag` is the selected half's store flag for a store and its load flag for a load.
- R9: When `faultValid` is set, `physAddr` and `capFlag` are 0.
- R10: All outputs are registered. A request on cycle n gives `rspValid`=1 and its results after edge n+1. A cycle without a request gives `rspValid`=0 and all-zero outputs. Reset clears every output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present this cycle |
| hit | input | 1 | Associative search found an entry |
| isStore | input | 1 | 1 = store access, 0 = load |
| vAddr | input | 64 | Virtual address |
| pageMask | input | 16 | Page-size mask of the matched entry |
| pfnEven | input | 24 | Frame number, even half |
| pfnOdd | input | 24 | Frame number, odd half |
| validEven | input | 1 | Valid bit, even half |
| validOdd | input | 1 | Valid bit, odd half |
| dirtyEven | input | 1 | Dirty (writable) bit, even half |
| dirtyOdd | input | 1 | Dirty (writable) bit, odd half |
| capStEven | input | 1 | Store capability flag, even half |
| capStOdd | input | 1 | Store capability flag, odd half |
| capLdEven | input | 1 | Load capability flag, even half |
| capLdOdd | input | 1 | Load capability flag, odd half |
| rspValid | output | 1 | Response present |
| physAddr | output | 64 | Translated physical address |
| capFlag | output | 1 | Capability flag for this access |
| faultValid | output | 1 | A fault is reported |
| faultCode | output | 3 | Fault cause code |
| badMask | output | 1 | Mask value is not a legal page size |

## Verification
Each of the nine legal masks is driven with the select bit both set and clear. A decoder that is off by one position would pick the wrong half, and a splice in the wrong place would corrupt the address bits near the boundary. Masks one bit away from legal values check that such near-misses raise the illegal-mask flag rather than being rounded to a page size. The bench also drives a miss with an illegal mask, to confirm that refill takes priority. Stores and loads to clean and invalid halves check the fault ordering and the store/load variants. A design that swapped these would report modify where invalid is due, or would let a store to a clean page through.

// File: rtl/page_xlate_pkg.sv
package page_xlate_pkg;
  localparam int PFN_W      = 24;
  localparam int PAGE_SHIFT = 12;
  localparam int NUM_SIZES  = 9;
  localparam int MASK_W     = 16;
  localparam int VA_W       = 64;
  localparam int SIZE_IDX_W = $clog2(NUM_SIZES);

  typedef enum logic [2:0] {
    FC_NONE      = 3'd0,
    FC_REFILL_LD = 3'd1,
    FC_REFILL_ST = 3'd2,
    FC_INVAL_LD  = 3'd3,
    FC_INVAL_ST  = 3'd4,
    FC_MODIFY    = 3'd5
  } faultCode_e;

  typedef struct packed {
    logic                  useOdd;
    logic [SIZE_IDX_W-1:0] sizeIdx;
    logic                  fault;
    faultCode_e            code;
    logic                  badMask;
    logic                  passPa;
  } xlateCtl_t;
endpackage

// File: rtl/page_xlate_ctrl.sv
module page_xlate_ctrl
  import page_xlate_pkg::*;
#(
  parameter int NumSizes  = NUM_SIZES,
  parameter int MaskW     = MASK_W,
  parameter int VaW       = VA_W,
  parameter int BaseShift = PAGE_SHIFT
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           hit,
  input  logic           isStore,
  input  logic [MaskW-1:0] pageMask,
  input  logic [VaW-1:0] vAddr,
  input  logic           validEven,
  input  logic           validOdd,
  input  logic           dirtyEven,
  input  logic           dirtyOdd,
  output xlateCtl_t      ctl
);
  logic [NumSizes-1:0] sizeHit;
  logic [NumSizes-1:0] selBitVec;
  logic [SIZE_IDX_W-1:0] sizeIdx;
  logic oddSel;
  logic legal;
  logic selValid;
  logic selDirty;

  // one comparator and one select tap per supported page size
  for (genvar k = 0; k < NumSizes; k++) begin : g_size
    localparam int SelPos = BaseShift + 2 * k;
    assign sizeHit[k]   = (pageMask == MaskW'((64'd1 << (2 * k)) - 64'd1));
    assign selBitVec[k] = vAddr[SelPos];
  end

  always_comb begin
    sizeIdx = '0;
    oddSel  = 1'b0;
    for (int k = 0; k < NumSizes; k++) begin
      if (sizeHit[k]) begin
        sizeIdx = SIZE_IDX_W'(k);
        oddSel  = selBitVec[k];
      end
    end
  end

  assign legal    = |sizeHit;
  assign selValid = oddSel ? validOdd : validEven;
  assign selDirty = oddSel ? dirtyOdd : dirtyEven;

  // priority: miss, illegal mask, invalid half, clean store, pass
  always_comb begin
    ctl         = '0;
    ctl.code    = FC_NONE;
    ctl.useOdd  = oddSel;
    ctl.sizeIdx = sizeIdx;
    if (!hit) begin
      ctl.fault = 1'b1;
      ctl.code  = isStore ? FC_REFILL_ST : FC_REFILL_LD;
    end else if (!legal) begin
      ctl.badMask = 1'b1;
    end else if (!selValid) begin
      ctl.fault = 1'b1;
      ctl.code  = isStore ? FC_INVAL_ST : FC_INVAL_LD;
    end else if (isStore && !selDirty) begin
      ctl.fault = 1'b1;
      ctl.code  = FC_MODIFY;
    end else begin
      ctl.passPa = 1'b1;
    end
  end

  AST_PASS_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    ctl.passPa |-> (ctl.useOdd ? validOdd : validEven)); // R5
  AST_STORE_NEEDS_DIRTY: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.passPa && isStore) |-> (ctl.useOdd ? dirtyOdd : dirtyEven)); // R6
  AST_MISS_NOT_BADMASK: assert property (@(posedge clk) disable iff (!rstN)
    !hit |-> (!ctl.badMask && ctl.fault)); // R4
  AST_BADMASK_NO_PASS: assert property (@(posedge clk) disable iff (!rstN)
    ctl.badMask |-> (!ctl.passPa && !ctl.fault)); // R2
endmodule

// File: rtl/page_xlate_dpath.sv
module page_xlate_dpath
  import page_xlate_pkg::*;
#(
  parameter int PfnW      = PFN_W,
  parameter int BaseShift = PAGE_SHIFT,
  parameter int NumSizes  = NUM_SIZES,
  parameter int VaW       = VA_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  input  logic            isStore,
  input  logic [VaW-1:0]  vAddr,
  input  logic [PfnW-1:0] pfnEven,
  input  logic [PfnW-1:0] pfnOdd,
  input  logic            capStEven,
  input  logic            capStOdd,
  input  logic            capLdEven,
  input  logic            capLdOdd,
  input  xlateCtl_t       ctl,
  output logic            rspValid,
  output logic [VaW-1:0]  physAddr,
  output logic            capFlag,
  output logic            faultValid,
  output logic [2:0]      faultCode,
  output logic            badMask
);
  localparam int PaW = PfnW + BaseShift;

  logic [PfnW-1:0] pfnSel;
  logic            capSel;
  logic [PaW-1:0]  paCand [NumSizes];
  logic [PaW-1:0]  paMux;

  assign pfnSel = ctl.useOdd ? pfnOdd : pfnEven;
  assign capSel = isStore ? (ctl.useOdd ? capStOdd : capStEven)
                          : (ctl.useOdd ? capLdOdd : capLdEven);

  // splice point moves two bits per size step
  for (genvar k = 0; k < NumSizes; k++) begin : g_splice
    localparam int OffW = BaseShift + 2 * k;
    assign paCand[k] = {pfnSel[PfnW-1:OffW-BaseShift], vAddr[OffW-1:0]};
  end

  always_comb begin
    paMux = '0;
    for (int k = 0; k < NumSizes; k++) begin
      if (ctl.sizeIdx == SIZE_IDX_W'(k)) paMux = paCand[k];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid   <= 1'b0;
      physAddr   <= '0;
      capFlag    <= 1'b0;
      faultValid <= 1'b0;
      faultCode  <= '0;
      badMask    <= 1'b0;
    end else if (reqValid) begin
      rspValid   <= 1'b1;
      physAddr   <= ctl.passPa ? VaW'(paMux) : '0;
      capFlag    <= ctl.passPa & capSel;
      faultValid <= ctl.fault;
      faultCode  <= ctl.code;
      badMask    <= ctl.badMask;
    end else begin
      rspValid   <= 1'b0;
      physAddr   <= '0;
      capFlag    <= 1'b0;
      faultValid <= 1'b0;
      faultCode  <= '0;
      badMask    <= 1'b0;
    end
  end

  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!rspValid && physAddr == '0 && !faultValid && !badMask)); // R10
  AST_PA_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (physAddr[VaW-1:PaW] == '0)); // R7
  AST_FAULT_CLEARS_PA: assert property (@(posedge clk) disable iff (!rstN)
    (faultValid || badMask) |-> (physAddr == '0 && !capFlag)); // R9
  AST_FAULT_CODE_SET: assert property (@(posedge clk) disable iff (!rstN)
    faultValid |-> (faultCode != 3'd0 && !badMask)); // R4
endmodule

// File: rtl/page_xlate.sv
module page_xlate
  import page_xlate_pkg::*;
#(
  parameter int PfnW      = PFN_W,
  parameter int MaskW     = MASK_W,
  parameter int VaW       = VA_W,
  parameter int BaseShift = PAGE_SHIFT,
  parameter int NumSizes  = NUM_SIZES
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             hit,
  input  logic             isStore,
  input  logic [VaW-1:0]   vAddr,
  input  logic [MaskW-1:0] pageMask,
  input  logic [PfnW-1:0]  pfnEven,
  input  logic [PfnW-1:0]  pfnOdd,
  input  logic             validEven,
  input  logic             validOdd,
  input  logic             dirtyEven,
  input  logic             dirtyOdd,
  input  logic             capStEven,
  input  logic             capStOdd,
  input  logic             capLdEven,
  input  logic             capLdOdd,
  output logic             rspValid,
  output logic [VaW-1:0]   physAddr,
  output logic             capFlag,
  output logic             faultValid,
  output logic [2:0]       faultCode,
  output logic             badMask
);
  xlateCtl_t ctl;

  page_xlate_ctrl #(
    .NumSizes(NumSizes), .MaskW(MaskW), .VaW(VaW), .BaseShift(BaseShift)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .hit(hit), .isStore(isStore),
    .pageMask(pageMask), .vAddr(vAddr),
    .validEven(validEven), .validOdd(validOdd),
    .dirtyEven(dirtyEven), .dirtyOdd(dirtyOdd),
    .ctl(ctl)
  );

  page_xlate_dpath #(
    .PfnW(PfnW), .BaseShift(BaseShift), .NumSizes(NumSizes), .VaW(VaW)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .isStore(isStore),
    .vAddr(vAddr), .pfnEven(pfnEven), .pfnOdd(pfnOdd),
    .capStEven(capStEven), .capStOdd(capStOdd),
    .capLdEven(capLdEven), .capLdOdd(capLdOdd),
    .ctl(ctl),
    .rspValid(rspValid), .physAddr(physAddr), .capFlag(capFlag),
    .faultValid(faultValid), .faultCode(faultCode), .badMask(badMask)
  );
endmodule

// File: tb/page_xlate_tb.sv
module page_xlate_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, hit = 1'b0, isStore = 1'b0;
  logic [63:0] vAddr = '0;
  logic [15:0] pageMask = '0;
  logic [23:0] pfnEven = '0, pfnOdd = '0;
  logic validEven = 1'b0, validOdd = 1'b0, dirtyEven = 1'b0, dirtyOdd = 1'b0;
  logic capStEven = 1'b0, capStOdd = 1'b0, capLdEven = 1'b0, capLdOdd = 1'b0;
  logic rspValid, capFlag, faultValid, badMask;
  logic [63:0] physAddr;
  logic [2:0] faultCode;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #10ns clk = ~clk;

  page_xlate u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .hit(hit), .isStore(isStore),
    .vAddr(vAddr), .pageMask(pageMask), .pfnEven(pfnEven), .pfnOdd(pfnOdd),
    .validEven(validEven), .validOdd(validOdd), .dirtyEven(dirtyEven),
    .dirtyOdd(dirtyOdd), .capStEven(capStEven), .capStOdd(capStOdd),
    .capLdEven(capLdEven), .capLdOdd(capLdOdd),
    .rspValid(rspValid), .physAddr(physAddr), .capFlag(capFlag),
    .faultValid(faultValid), .faultCode(faultCode), .badMask(badMask)
  );

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // reference model written from the requirements
  logic [63:0] expPa;
  logic expCap, expFv, expBad;
  logic [2:0] expCode;
  string tagPa, tagFlt;

  task automatic model();
    int sel = -1;
    logic odd, v, d;
    logic [23:0] pfn;
    logic [35:0] offMask;
    for (int k = 0; k < 9; k++)
      if (pageMask == (16'hFFFF >> (16 - 2 * k))) sel = 12 + 2 * k; // R1
    expPa = '0; expCap = 1'b0; expFv = 1'b0; expBad = 1'b0; expCode = 3'd0;
    tagPa = "R7"; tagFlt = "R6";
    if (!hit) begin
      expFv = 1'b1; expCode = isStore ? 3'd2 : 3'd1; tagPa = "R9"; tagFlt = "R4";
    end else if (sel < 0) begin
      expBad = 1'b1; tagPa = "R2"; tagFlt = "R2";
    end else begin
      odd = vAddr[sel];                        // R3
      v = odd ? validOdd : validEven;
      d = odd ? dirtyOdd : dirtyEven;
      pfn = odd ? pfnOdd : pfnEven;
      if (!v) begin
        expFv = 1'b1; expCode = isStore ? 3'd4 : 3'd3; tagPa = "R9"; tagFlt = "R5";
      end else if (isStore && !d) begin
        expFv = 1'b1; expCode = 3'd5; tagPa = "R9"; tagFlt = "R6";
      end else begin
        offMask = (36'd1 << sel) - 36'd1;
        expPa = {28'd0, ({pfn, 12'd0} & ~offMask) | (vAddr[35:0] & offMask)};
        expCap = isStore ? (odd ? capStOdd : capStEven) : (odd ? capLdOdd : capLdEven); // R8
      end
    end
  endtask

  task automatic doTxn();
    @(negedge clk);
    reqValid = 1'b1;
    model();
    @(negedge clk);
    reqValid = 1'b0;
    check("R10", "rspValid", {63'd0, rspValid}, 64'd1);
    check(tagPa, "physAddr", physAddr, expPa);
    check("R8", "capFlag", {63'd0, capFlag}, {63'd0, expCap});
    check(tagFlt, "faultValid", {63'd0, faultValid}, {63'd0, expFv});
    check(tagFlt, "faultCode", {61'd0, faultCode}, {61'd0, expCode});
    check("R2", "badMask", {63'd0, badMask}, {63'd0, expBad});
  endtask

  task automatic setHalves(logic ve, logic vo, logic de, logic dO);
    validEven = ve; validOdd = vo; dirtyEven = de; dirtyOdd = dO;
  endtask

  task automatic randFields();
    vAddr = {$urandom(), $urandom()};
    pfnEven = 24'($urandom()); pfnOdd = 24'($urandom());
    {capStEven, capStOdd, capLdEven, capLdOdd} = 4'($urandom());
  endtask

  initial begin
    #4000000ns;
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // reset state R10
    check("R10", "reset rspValid", {63'd0, rspValid}, 64'd0);
    check("R10", "reset physAddr", physAddr, 64'd0);
    check("R10", "reset faultCode", {61'd0, faultCode}, 64'd0);
    rstN = 1'b1;

    // R1 R3 R7: every legal size, both halves, dirty so stores pass
    hit = 1'b1;
    for (int k = 0; k < 9; k++) begin
      for (int o = 0; o < 2; o++) begin
        for (int s = 0; s < 2; s++) begin
          randFields();
          pageMask = 16'hFFFF >> (16 - 2 * k);
          vAddr[12 + 2 * k] = o[0];
          isStore = s[0];
          setHalves(1'b1, 1'b1, 1'b1, 1'b1);
          doTxn();
        end
      end
    end

    // R2: near-miss masks
    randFields(); setHalves(1'b1, 1'b1, 1'b1, 1'b1);
    pageMask = 16'h0001; isStore = 1'b0; doTxn();
    pageMask = 16'h0007; doTxn();
    pageMask = 16'h7FFF; isStore = 1'b1; doTxn();
    pageMask = 16'hFFFE; doTxn();

    // R4: miss beats an illegal mask
    hit = 1'b0; pageMask = 16'h0005; isStore = 1'b1; doTxn();
    isStore = 1'b0; doTxn();
    hit = 1'b1;

    // R5: invalid selected half, other half valid
    pageMask = 16'h00FF; randFields();
    vAddr[20] = 1'b1; setHalves(1'b1, 1'b0, 1'b1, 1'b1);
    isStore = 1'b1; doTxn();
    isStore = 1'b0; doTxn();

    // R6: clean half: store faults, load passes
    vAddr[20] = 1'b0; setHalves(1'b1, 1'b1, 1'b0, 1'b1);
    isStore = 1'b1; doTxn();
    isStore = 1'b0; doTxn();

    // R10: idle cycle clears outputs
    @(negedge clk);
    check("R10", "idle rspValid", {63'd0, rspValid}, 64'd0);
    check("R10", "idle physAddr", physAddr, 64'd0);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      randFields();
      hit = ($urandom_range(99) < 88);
      isStore = $urandom_range(1);
      if ($urandom_range(99) < 85) pageMask = 16'hFFFF >> (16 - 2 * $urandom_range(8));
      else pageMask = 16'($urandom());
      {validEven, validOdd, dirtyEven, dirtyOdd} = 4'($urandom() | 32'($urandom_range(1) ? 15 : 0));
      doTxn();
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule